// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline and decides, each cycle, whether the instruction being decoded must wait one cycle for a load ahead of it. A load's result only exists once its memory access has finished. An instruction that reads the loaded register in the cycle directly after the load cannot be served by forwarding alone. When the unit sees this case, it freezes the program counter and the fetch/decode register, and it clears the control word on its way into the execute-stage register. That empty control word is the bubble.

The decision is purely combinational and is taken in the same cycle as the inputs. The unit compares two inputs. The first is the load flag and destination register index held in the execute-stage register. The second is the two source register fields of the instruction word in decode. Forwarding after the bubble, branch stalls and resource-conflict stalls are handled by other blocks.

Top module: `lu_hazard_unit`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals the first source field `dec_instr[25:21]`, `bubble_sel` is 1 in the same cycle.
- R2: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals the second source field `dec_instr[20:16]`, `bubble_sel` is 1 in the same cycle.
- R3: When `ex_is_load` is 0, `bubble_sel` is 0 whatever the register fields hold.
- R4: When `ex_dst` is register 0, `bubble_sel` is 0 even if a source field is also 0 and a load is present.
- R5: When `ex_dst` matches neither source field, `bubble_sel` is 0.
- R6: While `bubble_sel` is 1, `pc_we` and `fetch_we` are both 0. Otherwise both are 1, and this includes the idle state seen under reset.
- R7: While `bubble_sel` is 1, `ctrl_out` is all zeros. Otherwise `ctrl_out` equals `ctrl_in` bit for bit.
- R8: In a pipeline whose execute-stage register is loaded from `ctrl_out`, a load followed directly by a user of its destination produces exactly one bubble cycle. The user instruction stays in the fetch/decode register across that cycle.
- R9: If independent loads are placed between a load and the instruction that uses its result, no bubble occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the embedded properties |
| rst | input | 1 | Synchronous active-high reset; holds the properties off |
| ex_is_load | input | 1 | Execute-stage register holds a load (memory read) |
| ex_dst | input | 5 | Destination register index of the instruction in execute |
| dec_instr | input | 32 | Instruction word held in the fetch/decode register |
| ctrl_in | input | CTRL_W (9) | Decoded control word headed for the execute-stage register |
| pc_we | output | 1 | Program counter write enable |
| fetch_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | 1 while a bubble is being inserted |
| ctrl_out | output | CTRL_W (9) | Control word into the execute-stage register, zero during a bubble |

## Verification
The single-cycle property for R8 relies on the execute-stage inputs being fed from this unit's own `ctrl_out`: after a bubble, `ex_is_load` must read 0. A load cannot stay in execute on its own. The bench respects this in two ways. In its directed phase it places an idle cycle with no load between any two vectors. In its pipeline phase it drives `ex_is_load` and `ex_dst` from a modelled execute register that takes the bubble. All other properties are pure same-cycle relations between ports and need no constraint on the stimulus.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int NUM_SRC  = 2;
    // first source field starts here; each next one sits REG_W lower
    localparam int SRC0_LSB = 21;

    typedef logic [REG_W-1:0] reg_idx_t;

    // what the execute stage reports about its instruction
    typedef struct packed {
        logic     mem_rd;
        reg_idx_t dst;
    } ex_tag_t;

    // front-end hold decisions
    typedef struct packed {
        logic hold_pc;
        logic hold_fetch;
        logic bubble;
    } stall_ctl_t;

    function automatic int src_lsb(int idx);
        return SRC0_LSB - idx * REG_W;
    endfunction

endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
    parameter int INSTR_W = lu_pkg::INSTR_W,
    parameter int NUM_SRC = lu_pkg::NUM_SRC
) (
    input  logic [INSTR_W-1:0] instr,
    input  lu_pkg::ex_tag_t    tag,
    output logic [NUM_SRC-1:0] hit
);

    logic tag_live;

    // register 0 is never a real producer
    assign tag_live = tag.mem_rd && (tag.dst != '0);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int LSB = lu_pkg::src_lsb(g);
        lu_pkg::reg_idx_t src;
        assign src    = instr[LSB +: lu_pkg::REG_W];
        assign hit[g] = tag_live && (src == tag.dst);
    end

endmodule

// File: rtl/lu_stall_ctl.sv
module lu_stall_ctl #(
    parameter int NUM_SRC = lu_pkg::NUM_SRC
) (
    input  logic [NUM_SRC-1:0] hit,
    output lu_pkg::stall_ctl_t ctl
);

    logic stall;

    assign stall = |hit;

    always_comb begin
        ctl            = '0;
        ctl.hold_pc    = stall;
        ctl.hold_fetch = stall;
        ctl.bubble     = stall;
    end

endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux #(
    parameter int CTRL_W = 9
) (
    input  logic              sel,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] ctrl_out
);

    assign ctrl_out = sel ? '0 : ctrl_in;

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit #(
    parameter int CTRL_W = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ex_is_load,
    input  logic [lu_pkg::REG_W-1:0]   ex_dst,
    input  logic [lu_pkg::INSTR_W-1:0] dec_instr,
    input  logic [CTRL_W-1:0]          ctrl_in,
    output logic                       pc_we,
    output logic                       fetch_we,
    output logic                       bubble_sel,
    output logic [CTRL_W-1:0]          ctrl_out
);

    localparam int RS_LSB = lu_pkg::src_lsb(0);
    localparam int RT_LSB = lu_pkg::src_lsb(1);

    lu_pkg::ex_tag_t                  tag;
    logic [lu_pkg::NUM_SRC-1:0]       hit;
    lu_pkg::stall_ctl_t               ctl;
    lu_pkg::reg_idx_t                 rs_f;
    lu_pkg::reg_idx_t                 rt_f;

    assign tag.mem_rd = ex_is_load;
    assign tag.dst    = ex_dst;

    lu_src_match #(
        .INSTR_W (lu_pkg::INSTR_W),
        .NUM_SRC (lu_pkg::NUM_SRC)
    ) match_i (
        .instr (dec_instr),
        .tag   (tag),
        .hit   (hit)
    );

    lu_stall_ctl #(
        .NUM_SRC (lu_pkg::NUM_SRC)
    ) ctl_i (
        .hit (hit),
        .ctl (ctl)
    );

    lu_bubble_mux #(
        .CTRL_W (CTRL_W)
    ) mux_i (
        .sel      (ctl.bubble),
        .ctrl_in  (ctrl_in),
        .ctrl_out (ctrl_out)
    );

    assign pc_we      = !ctl.hold_pc;
    assign fetch_we   = !ctl.hold_fetch;
    assign bubble_sel = ctl.bubble;

    assign rs_f = dec_instr[RS_LSB +: lu_pkg::REG_W];
    assign rt_f = dec_instr[RT_LSB +: lu_pkg::REG_W];

    // R1: load into the first source register forces a bubble
    p_rs_hit_r1: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_dst != '0 && ex_dst == rs_f) |-> bubble_sel);

    // R2: load into the second source register forces a bubble
    p_rt_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_dst != '0 && ex_dst == rt_f) |-> bubble_sel);

    p_no_load_r3: assert property (@(posedge clk) disable iff (rst)
        !ex_is_load |-> !bubble_sel);

    p_reg_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> !bubble_sel);

    p_no_match_r5: assert property (@(posedge clk) disable iff (rst)
        (ex_dst != rs_f && ex_dst != rt_f) |-> !bubble_sel);

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |-> (!pc_we && !fetch_we));

    p_run_r6: assert property (@(posedge clk) disable iff (rst)
        !bubble_sel |-> (pc_we && fetch_we));

    p_zero_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |-> (ctrl_out == '0));

    p_pass_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
        !bubble_sel |-> (ctrl_out == ctrl_in));

    // R8: relies on the execute register taking ctrl_out, see brief
    p_single_r8: assert property (@(posedge clk) disable iff (rst)
        bubble_sel |=> !bubble_sel);

endmodule

// File: tb/lu_hazard_unit_tb_top.sv
module lu_hazard_unit_tb_top;

    localparam int CTRL_W = 9;
    localparam logic [5:0] OP_LOAD = 6'b100011;
    localparam logic [5:0] OP_ALU  = 6'b000000;
    localparam logic [CTRL_W-1:0] CTRL_LD  = 9'h0C3;
    localparam logic [CTRL_W-1:0] CTRL_ALU = 9'h121;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst;
    logic mode_pipe;

    // directed-phase drivers
    logic              d_ld;
    logic [4:0]        d_dst;
    logic [31:0]       d_instr;
    logic [CTRL_W-1:0] d_ctrl;

    // pipeline-phase model
    logic              pipe_rst;
    logic [31:0]       prog [16];
    logic [3:0]        p_pc;
    logic [31:0]       p_fetch;
    logic              p_ld;
    logic [4:0]        p_dst;

    logic              ex_is_load;
    logic [4:0]        ex_dst;
    logic [31:0]       dec_instr;
    logic [CTRL_W-1:0] ctrl_in;
    logic              pc_we;
    logic              fetch_we;
    logic              bubble_sel;
    logic [CTRL_W-1:0] ctrl_out;

    assign ex_is_load = mode_pipe ? p_ld    : d_ld;
    assign ex_dst     = mode_pipe ? p_dst   : d_dst;
    assign dec_instr  = mode_pipe ? p_fetch : d_instr;
    assign ctrl_in    = mode_pipe ? ((p_fetch[31:26] == OP_LOAD) ? CTRL_LD : CTRL_ALU) : d_ctrl;

    lu_hazard_unit #(.CTRL_W(CTRL_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ex_is_load (ex_is_load),
        .ex_dst     (ex_dst),
        .dec_instr  (dec_instr),
        .ctrl_in    (ctrl_in),
        .pc_we      (pc_we),
        .fetch_we   (fetch_we),
        .bubble_sel (bubble_sel),
        .ctrl_out   (ctrl_out)
    );

    always_ff @(posedge clk) begin
        if (pipe_rst) begin
            p_pc    <= '0;
            p_fetch <= '0;
            p_ld    <= 1'b0;
            p_dst   <= '0;
        end else begin
            if (pc_we)    p_pc    <= p_pc + 4'd1;
            if (fetch_we) p_fetch <= prog[p_pc];
            p_ld  <= !bubble_sel && (p_fetch[31:26] == OP_LOAD);
            p_dst <= p_fetch[20:16];
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard queues
    bit                q_stall [$];
    logic [CTRL_W-1:0] q_ctrl  [$];
    string             q_req   [$];

    // pipeline-phase observations
    int          bub_cnt;
    int          dbl_cnt;
    int          held_bad;
    bit          prev_bub;
    logic [31:0] held_word;

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {op, rs, rt, rd, 11'd0};
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_vec(logic ld, logic [4:0] dst, logic [31:0] ins, logic [CTRL_W-1:0] c, string req);
        bit exp_stall;
        @(negedge clk);
        d_ld = ld; d_dst = dst; d_instr = ins; d_ctrl = c;
        exp_stall = ld && (dst != 5'd0) && (dst == ins[25:21] || dst == ins[20:16]);
        q_stall.push_back(exp_stall);
        q_ctrl.push_back(exp_stall ? '0 : c);
        q_req.push_back(req);
        @(negedge clk);
        d_ld = 1'b0; d_dst = 5'd0; d_instr = '0; d_ctrl = '0;   // idle gap
    endtask

    // monitor: compare against the scoreboard away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_stall.size() > 0) begin
                bit                s;
                logic [CTRL_W-1:0] c;
                string             r;
                s = q_stall.pop_front();
                c = q_ctrl.pop_front();
                r = q_req.pop_front();
                checks++;
                if (bubble_sel !== s || pc_we !== !s || fetch_we !== !s || ctrl_out !== c) begin
                    errors++;
                    $display("FAIL %s: bubble=%0b pc_we=%0b fetch_we=%0b ctrl=%h expected bubble=%0b ctrl=%h",
                             r, bubble_sel, pc_we, fetch_we, ctrl_out, s, c);
                end
            end
            if (mode_pipe && !pipe_rst) begin
                if (prev_bub && p_fetch !== held_word) held_bad++;
                if (prev_bub && bubble_sel) dbl_cnt++;
                if (bubble_sel) begin
                    bub_cnt++;
                    held_word = p_fetch;
                end
                prev_bub = bubble_sel;
            end
        end
    end

    task automatic run_prog(string req, int exp_bub);
        @(negedge clk);
        pipe_rst = 1'b1;
        mode_pipe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bub_cnt = 0; dbl_cnt = 0; held_bad = 0; prev_bub = 1'b0;
        pipe_rst = 1'b0;
        repeat (12) @(negedge clk);
        #3;
        check_eq(req, "bubble count", bub_cnt, exp_bub);
        check_eq(req, "back-to-back bubbles", dbl_cnt, 0);
        check_eq(req, "held word changed", held_bad, 0);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = mk(OP_ALU, 5'd0, 5'd0, 5'd0);
    endtask

    initial begin
        rst = 1'b1; mode_pipe = 1'b0; pipe_rst = 1'b1;
        d_ld = 1'b0; d_dst = '0; d_instr = '0; d_ctrl = '0;
        clear_prog();

        // reset state: idle inputs, front end running (R6)
        @(negedge clk);
        d_ctrl = 9'h155;
        q_stall.push_back(1'b0); q_ctrl.push_back(9'h155); q_req.push_back("R6 reset");
        @(negedge clk);
        d_ctrl = '0;
        @(negedge clk);
        rst = 1'b0;

        drive_vec(1'b1, 5'd8,  mk(OP_ALU, 5'd8,  5'd3,  5'd4), 9'h1FF, "R1");
        drive_vec(1'b1, 5'd31, mk(OP_ALU, 5'd31, 5'd1,  5'd2), 9'h0AA, "R1 top index");
        drive_vec(1'b1, 5'd8,  mk(OP_ALU, 5'd3,  5'd8,  5'd4), 9'h1FF, "R2");
        drive_vec(1'b1, 5'd8,  mk(OP_ALU, 5'd8,  5'd8,  5'd4), 9'h1FF, "R2 both fields");
        drive_vec(1'b0, 5'd8,  mk(OP_ALU, 5'd8,  5'd8,  5'd4), 9'h0F0, "R3");
        drive_vec(1'b1, 5'd0,  mk(OP_ALU, 5'd0,  5'd0,  5'd4), 9'h111, "R4");
        drive_vec(1'b1, 5'd8,  mk(OP_ALU, 5'd7,  5'd9,  5'd8), 9'h1C3, "R5 rd field ignored");
        drive_vec(1'b1, 5'd8,  mk(OP_LOAD, 5'd9, 5'd10, 5'd0), 9'h0C3, "R5");
        drive_vec(1'b0, 5'd0,  mk(OP_ALU, 5'd1,  5'd2,  5'd3), 9'h1A5, "R7 pass");
        drive_vec(1'b1, 5'd2,  mk(OP_ALU, 5'd1,  5'd2,  5'd3), 9'h1A5, "R7 zero");

        for (int k = 0; k < 40; k++) begin
            drive_vec(1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
                      mk(6'($urandom), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom)),
                      9'($urandom), "R7 random");
        end
        @(negedge clk);
        @(negedge clk);

        // R8: load then immediate user via the first source field
        clear_prog();
        prog[0] = mk(OP_LOAD, 5'd9, 5'd8,  5'd0);
        prog[1] = mk(OP_ALU,  5'd8, 5'd11, 5'd10);
        run_prog("R8 rs user", 1);

        // R8: user reads the loaded register through the second field
        clear_prog();
        prog[0] = mk(OP_LOAD, 5'd9,  5'd8, 5'd0);
        prog[1] = mk(OP_ALU,  5'd11, 5'd8, 5'd10);
        run_prog("R8 rt user", 1);

        // R9: independent loads placed between loads and their users
        clear_prog();
        prog[0] = mk(OP_LOAD, 5'd9, 5'd8,  5'd0);
        prog[1] = mk(OP_LOAD, 5'd9, 5'd10, 5'd0);
        prog[2] = mk(OP_LOAD, 5'd9, 5'd12, 5'd0);
        prog[3] = mk(OP_ALU,  5'd8, 5'd10, 5'd11);
        prog[4] = mk(OP_ALU,  5'd8, 5'd12, 5'd13);
        run_prog("R9 reordered", 0);

        // R9 contrast: the original order stalls twice
        clear_prog();
        prog[0] = mk(OP_LOAD, 5'd9, 5'd8,  5'd0);
        prog[1] = mk(OP_LOAD, 5'd9, 5'd10, 5'd0);
        prog[2] = mk(OP_ALU,  5'd8, 5'd10, 5'd11);
        prog[3] = mk(OP_LOAD, 5'd9, 5'd12, 5'd0);
        prog[4] = mk(OP_ALU,  5'd8, 5'd12, 5'd13);
        run_prog("R9 original order", 2);

        // R4 in the pipeline: a load to register 0 never stalls
        clear_prog();
        prog[0] = mk(OP_LOAD, 5'd9, 5'd0, 5'd0);
        prog[1] = mk(OP_ALU,  5'd0, 5'd0, 5'd10);
        run_prog("R4 pipeline", 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule